// File: doc/BRIEF.md
# Bus Register Block with Committed-Transfer Qualification

This block is an AHB-Lite subordinate holding a small set of software registers, a sticky event register that clears when read, and a read queue that drops its head when read. It acts on an address phase only when that phase is a committed transfer. A committed transfer has all three of these in the same cycle: a real transfer type, its own select, and the shared system ready. An address left on the bus during idle, unselected or stalled cycles is never mistaken for an access. This matters most for the two registers whose reads change state.

The address phase is captured in one cycle and its effect lands in the following data-phase cycle. Writes take the write data of that data phase. Read data is presented combinationally during that data phase. The destructive effects (clearing the sticky bits and popping the queue) take place at the edge that ends the data phase. Every response is zero-wait and OKAY.

Hardware outside the block marks events through a per-bit set input. It loads the queue through a push input.

Top module: `ahb_qual_regblk`

## Requirements
- R1: After reset, every scratch register and the sticky event register read as zero, the queue is empty, and a read of the queue returns zero.
- R2: An address phase is committed only when the transfer type is NONSEQ (2'b10) or SEQ (2'b11), the select is high and the system ready input is high. A committed write stores the write data present in the next cycle. A committed read returns data in the next cycle.
- R3: A transfer type of IDLE (2'b00) or BUSY (2'b01) causes no write, no clear and no pop, even when the address decodes to a register.
- R4: With the select low, no write, clear or pop takes place.
- R5: With the system ready input low in the address phase, no write, clear or pop takes place. The block watches the system ready input, not its own ready output.
- R6: The ready output is always 1 and the response output is always OKAY (0), on idle and busy cycles as well as on transfers.
- R7: The sticky event register (word offset 0x8, low 8 bits) sets each bit whose set input is high. A committed read returns the current bits and clears them at the end of the data phase. A set arriving in that same cycle survives the clear.
- R8: The queue (word offset 0xC, depth 4) returns its head on a committed read and pops it. A read of an empty queue returns zero and pops nothing. A push into a full queue is dropped unless a pop happens in the same cycle. A push and a pop in one cycle are both honoured.
- R9: Scratch writes honour the transfer size: size 0 writes the byte lane selected by address bits [1:0], size 1 writes the half selected by address bit 1, and size 2 or larger writes the whole word.
- R10: Scratch registers sit at word offsets 0x0 and 0x4. Writes to the event register, to the queue address or to any unmapped address change nothing, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsel_i | input | 1 | Subordinate select |
| haddr_i | input | 32 | Address |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | Write flag |
| hsize_i | input | 3 | Transfer size |
| hready_i | input | 1 | System ready (shared) |
| hwdata_i | input | 32 | Write data (data phase) |
| hrdata_o | output | 32 | Read data (data phase) |
| hreadyout_o | output | 1 | Ready output, constant 1 |
| hresp_o | output | 1 | Response, constant OKAY |
| evt_set_i | input | 8 | Per-bit set for sticky event register |
| push_i | input | 1 | Queue push strobe |
| push_data_i | input | 32 | Queue push data |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, an event set meets the clear-on-read of the event register. In the second, a queue push meets a queue pop. The bench raises the set input or the push strobe during the data phase of a committed read of the same register. It judges the pair by the read value, which must be the old contents, and by the next committed read, which must show the new event bit or the pushed word. A separate run sets the same event bit that is being cleared and expects it to survive, then to clear on the following read.

// File: rtl/ahb_qual_pkg.sv
package ahb_qual_pkg;
  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [1:0] {
    RG_SCRATCH = 2'd0,
    RG_EVENT   = 2'd1,
    RG_QUEUE   = 2'd2,
    RG_NONE    = 2'd3
  } region_e;

  localparam logic RESP_OKAY = 1'b0;
endpackage

// File: rtl/ahb_qual_aphase.sv
module ahb_qual_aphase
  import ahb_qual_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int N_SCRATCH = 2,
  localparam int STRB_W   = DATA_W / 8,
  localparam int LANE_W   = $clog2(STRB_W),
  localparam int MAP_W    = $clog2(N_SCRATCH + 2),
  localparam int SIDX_W   = (N_SCRATCH > 1) ? $clog2(N_SCRATCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic              hready_i,
  output logic              dph_valid_o,
  output logic              dph_write_o,
  output region_e           dph_region_o,
  output logic [SIDX_W-1:0] dph_index_o,
  output logic [STRB_W-1:0] dph_strb_o
);
  logic              access_en;
  logic              real_trans;
  logic [MAP_W-1:0]  word_idx;
  logic              upper_zero;
  region_e           region_d;
  logic [STRB_W-1:0] strb_d;

  assign real_trans = (htrans_i == HT_NONSEQ) || (htrans_i == HT_SEQ);
  assign access_en  = real_trans && hsel_i && hready_i;

  assign word_idx   = haddr_i[LANE_W +: MAP_W];
  assign upper_zero = (haddr_i[ADDR_W-1:LANE_W+MAP_W] == '0);

  always_comb begin
    if (!upper_zero)                            region_d = RG_NONE;
    else if (int'(word_idx) < N_SCRATCH)        region_d = RG_SCRATCH;
    else if (int'(word_idx) == N_SCRATCH)       region_d = RG_EVENT;
    else if (int'(word_idx) == N_SCRATCH + 1)   region_d = RG_QUEUE;
    else                                        region_d = RG_NONE;
  end

  // byte lanes from size and low address bits, aligned to the transfer size
  always_comb begin
    int nbytes;
    int off;
    nbytes = (int'(hsize_i) >= LANE_W) ? STRB_W : (1 << hsize_i);
    off    = int'(haddr_i[LANE_W-1:0]) & ~(nbytes - 1);
    for (int b = 0; b < STRB_W; b++) begin
      strb_d[b] = (b >= off) && (b < off + nbytes);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dph_valid_o  <= 1'b0;
      dph_write_o  <= 1'b0;
      dph_region_o <= RG_NONE;
      dph_index_o  <= '0;
      dph_strb_o   <= '0;
    end else begin
      dph_valid_o <= access_en;
      if (access_en) begin
        dph_write_o  <= hwrite_i;
        dph_region_o <= region_d;
        dph_index_o  <= word_idx[SIDX_W-1:0];
        dph_strb_o   <= strb_d;
      end
    end
  end

  a_r2_commit_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsel_i && hready_i && htrans_i[1]) |=> dph_valid_o);
  a_r3_quiet_type_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!htrans_i[1]) |=> !dph_valid_o);
  a_r4_unselected_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hsel_i) |=> !dph_valid_o);
  a_r5_stall_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hready_i) |=> !dph_valid_o);
endmodule

// File: rtl/ahb_qual_regs.sv
module ahb_qual_regs #(
  parameter int DATA_W    = 32,
  parameter int N_SCRATCH = 2,
  parameter int EVT_W     = 8,
  localparam int STRB_W   = DATA_W / 8,
  localparam int SIDX_W   = (N_SCRATCH > 1) ? $clog2(N_SCRATCH) : 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [SIDX_W-1:0]              wr_index_i,
  input  logic [STRB_W-1:0]              wr_strb_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           evt_clr_i,
  input  logic [EVT_W-1:0]               evt_set_i,
  output logic [N_SCRATCH-1:0][DATA_W-1:0] scratch_o,
  output logic [EVT_W-1:0]               evt_o
);
  for (genvar i = 0; i < N_SCRATCH; i++) begin : g_scr
    logic hit;
    assign hit = wr_en_i && (wr_index_i == SIDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        scratch_o[i] <= '0;
      end else if (hit) begin
        for (int b = 0; b < STRB_W; b++) begin
          if (wr_strb_i[b]) scratch_o[i][b*8 +: 8] <= wr_data_i[b*8 +: 8];
        end
      end
    end
  end

  // a set in the clearing cycle wins so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        evt_o <= '0;
    else if (evt_clr_i) evt_o <= evt_set_i;
    else                evt_o <= evt_o | evt_set_i;
  end

  a_r7_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_clr_i && evt_set_i == '0) |=> (evt_o == '0));
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_clr_i) |=> ((evt_o & $past(evt_o)) == $past(evt_o)));
  a_r7_set_survives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_set_i != '0) |=> ((evt_o & $past(evt_set_i)) == $past(evt_set_i)));
  a_r10_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i) |=> $stable(scratch_o));
endmodule

// File: rtl/ahb_qual_fifo.sv
module ahb_qual_fifo #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  count_q;
  logic              full, pop_ok, push_ok;

  assign empty_o = (count_q == '0);
  assign full    = (count_q == CNT_W'(DEPTH));
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (!full || pop_ok);
  assign head_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (pop_ok)  rd_ptr_q <= ptr_next(rd_ptr_q);
      if (push_ok) wr_ptr_q <= ptr_next(wr_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  a_r8_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r8_hold_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i && !push_i) |=> $stable(count_q));
  a_r8_empty_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/ahb_qual_regblk.sv
module ahb_qual_regblk
  import ahb_qual_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int N_SCRATCH = 2,
  parameter int EVT_W     = 8,
  parameter int Q_DEPTH   = 4,
  localparam int STRB_W   = DATA_W / 8,
  localparam int SIDX_W   = (N_SCRATCH > 1) ? $clog2(N_SCRATCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hsel_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic              hready_i,
  input  logic [DATA_W-1:0] hwdata_i,
  output logic [DATA_W-1:0] hrdata_o,
  output logic              hreadyout_o,
  output logic              hresp_o,
  input  logic [EVT_W-1:0]  evt_set_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i
);
  logic              dph_valid, dph_write;
  region_e           dph_region;
  logic [SIDX_W-1:0] dph_index;
  logic [STRB_W-1:0] dph_strb;
  logic              dph_read;
  logic [N_SCRATCH-1:0][DATA_W-1:0] scratch;
  logic [EVT_W-1:0]  evt;
  logic [DATA_W-1:0] q_head;
  logic              q_empty;

  ahb_qual_aphase #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SCRATCH(N_SCRATCH)) u_aphase (
    .clk_i, .rst_ni, .hsel_i, .haddr_i, .htrans_i, .hwrite_i, .hsize_i, .hready_i,
    .dph_valid_o (dph_valid),
    .dph_write_o (dph_write),
    .dph_region_o(dph_region),
    .dph_index_o (dph_index),
    .dph_strb_o  (dph_strb)
  );

  assign dph_read = dph_valid && !dph_write;

  ahb_qual_regs #(.DATA_W(DATA_W), .N_SCRATCH(N_SCRATCH), .EVT_W(EVT_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i   (dph_valid && dph_write && dph_region == RG_SCRATCH),
    .wr_index_i(dph_index),
    .wr_strb_i (dph_strb),
    .wr_data_i (hwdata_i),
    .evt_clr_i (dph_read && dph_region == RG_EVENT),
    .evt_set_i,
    .scratch_o (scratch),
    .evt_o     (evt)
  );

  ahb_qual_fifo #(.DATA_W(DATA_W), .DEPTH(Q_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i, .push_data_i,
    .pop_i  (dph_read && dph_region == RG_QUEUE),
    .head_o (q_head),
    .empty_o(q_empty)
  );

  always_comb begin
    hrdata_o = '0;
    if (dph_read) begin
      case (dph_region)
        RG_SCRATCH: hrdata_o = scratch[dph_index];
        RG_EVENT:   hrdata_o = DATA_W'(evt);
        RG_QUEUE:   hrdata_o = q_empty ? '0 : q_head;
        default:    hrdata_o = '0;
      endcase
    end
  end

  assign hreadyout_o = 1'b1;
  assign hresp_o     = RESP_OKAY;

  a_r2_read_quiet_outside_dphase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dph_valid) |-> (hrdata_o == '0));
endmodule

// File: tb/sim_ahb_qual_regblk.sv
module sim_ahb_qual_regblk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'd2;
  logic        hready = 1'b1;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata;
  logic        hreadyout, hresp;
  logic [7:0]  evt_set = '0;
  logic        push = 1'b0;
  logic [31:0] push_data = '0;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ahb_qual_regblk u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsel_i(hsel), .haddr_i(haddr), .htrans_i(htrans),
    .hwrite_i(hwrite), .hsize_i(hsize), .hready_i(hready), .hwdata_i(hwdata),
    .hrdata_o(hrdata), .hreadyout_o(hreadyout), .hresp_o(hresp),
    .evt_set_i(evt_set), .push_i(push), .push_data_i(push_data)
  );

  typedef struct packed {
    logic        sel;
    logic [1:0]  trans;
    logic        rdy;
    logic        wr;
    logic [2:0]  size;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b10, 1'b1, 1'b1, 3'd2, 12'h000, 32'h11223344, 1'b0, 32'h0},        // R2 write
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h000, 32'h0, 1'b1, 32'h11223344},         // R2 read back
    '{1'b1, 2'b00, 1'b1, 1'b1, 3'd2, 12'h000, 32'hFFFFFFFF, 1'b0, 32'h0},         // R3 idle write
    '{1'b1, 2'b11, 1'b1, 1'b0, 3'd2, 12'h000, 32'h0, 1'b1, 32'h11223344},         // R3 unchanged, SEQ read
    '{1'b0, 2'b10, 1'b1, 1'b1, 3'd2, 12'h004, 32'hCAFEF00D, 1'b0, 32'h0},         // R4 unselected write
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h004, 32'h0, 1'b1, 32'h0},                // R4 unchanged
    '{1'b1, 2'b10, 1'b0, 1'b1, 3'd2, 12'h004, 32'h0BADBEEF, 1'b0, 32'h0},         // R5 stalled write
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h004, 32'h0, 1'b1, 32'h0},                // R5 unchanged
    '{1'b1, 2'b01, 1'b1, 1'b0, 3'd2, 12'h008, 32'h0, 1'b0, 32'h0},                // R3 busy read of event
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h008, 32'h0, 1'b1, 32'h5},                // R7 read returns bits
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h008, 32'h0, 1'b1, 32'h0},                // R7 cleared
    '{1'b1, 2'b00, 1'b1, 1'b0, 3'd2, 12'h00C, 32'h0, 1'b0, 32'h0},                // R3 idle queue read
    '{1'b0, 2'b10, 1'b1, 1'b0, 3'd2, 12'h00C, 32'h0, 1'b0, 32'h0},                // R4 unselected queue read
    '{1'b1, 2'b10, 1'b0, 1'b0, 3'd2, 12'h00C, 32'h0, 1'b0, 32'h0},                // R5 stalled queue read
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h00C, 32'h0, 1'b1, 32'hA1},               // R8 head, no phantom pops
    '{1'b1, 2'b11, 1'b1, 1'b0, 3'd2, 12'h00C, 32'h0, 1'b1, 32'hA2},               // R8 next
    '{1'b1, 2'b10, 1'b1, 1'b1, 3'd2, 12'h00C, 32'h0000DEAD, 1'b0, 32'h0},         // R10 write to queue ignored
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h008, 32'h0, 1'b1, 32'h0},                // R10 event still zero
    '{1'b1, 2'b10, 1'b1, 1'b1, 3'd2, 12'h030, 32'h12345678, 1'b0, 32'h0},         // R10 unmapped write
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h030, 32'h0, 1'b1, 32'h0},                // R10 unmapped read
    '{1'b1, 2'b10, 1'b1, 1'b1, 3'd0, 12'h001, 32'h0000AB00, 1'b0, 32'h0},         // R9 byte lane 1
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h000, 32'h0, 1'b1, 32'h1122AB44},         // R9
    '{1'b1, 2'b10, 1'b1, 1'b1, 3'd1, 12'h002, 32'h55660000, 1'b0, 32'h0},         // R9 upper half
    '{1'b1, 2'b10, 1'b1, 1'b0, 3'd2, 12'h000, 32'h0, 1'b1, 32'h5566AB44}          // R9
  };

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one address phase, then one data phase; rdata sampled mid data phase
  task automatic bus_op(input logic sel, input logic [1:0] trans, input logic rdy,
                        input logic wr, input logic [2:0] size, input logic [31:0] addr,
                        input logic [31:0] wdata, input logic [7:0] dset,
                        input logic dpush, input logic [31:0] dpdata,
                        output logic [31:0] rdata);
    @(negedge clk);
    hsel = sel; htrans = trans; hready = rdy; hwrite = wr; hsize = size; haddr = addr;
    evt_set = '0; push = 1'b0;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hready = 1'b1; hwrite = 1'b0; hwdata = wdata;
    evt_set = dset; push = dpush; push_data = dpdata;
    #1;
    rdata = hrdata;
    check_eq("R6 ready/okay", {30'd0, hreadyout, hresp}, 32'h2);
  endtask

  task automatic rd(input logic [31:0] addr, input logic [7:0] dset, input logic dpush,
                    input logic [31:0] dpdata, input string tag, input logic [31:0] exp);
    logic [31:0] r;
    bus_op(1'b1, 2'b10, 1'b1, 1'b0, 3'd2, addr, 32'h0, dset, dpush, dpdata, r);
    check_eq(tag, r, exp);
  endtask

  task automatic quiet();
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; evt_set = '0; push = 1'b0;
  endtask

  task automatic pulse_push(input logic [31:0] d);
    @(negedge clk); push = 1'b1; push_data = d; evt_set = '0;
    @(negedge clk); push = 1'b0;
  endtask

  task automatic pulse_set(input logic [7:0] s);
    @(negedge clk); evt_set = s; push = 1'b0;
    @(negedge clk); evt_set = '0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(32'h0, 8'h0, 1'b0, 32'h0, "R1 scratch0", 32'h0);
    rd(32'h4, 8'h0, 1'b0, 32'h0, "R1 scratch1", 32'h0);
    rd(32'h8, 8'h0, 1'b0, 32'h0, "R1 event", 32'h0);
    rd(32'hC, 8'h0, 1'b0, 32'h0, "R1 queue empty", 32'h0);
    quiet();

    pulse_set(8'h05);
    pulse_push(32'hA1);
    pulse_push(32'hA2);
    pulse_push(32'hA3);

    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].sel, VECS[i].trans, VECS[i].rdy, VECS[i].wr, VECS[i].size,
             {20'h0, VECS[i].addr}, VECS[i].wdata, 8'h0, 1'b0, 32'h0, r);
      if (VECS[i].chk) check_eq($sformatf("vector %0d", i), r, VECS[i].exp);
    end
    quiet();

    // R7 set during clearing read survives
    pulse_set(8'h01);
    rd(32'h8, 8'h02, 1'b0, 32'h0, "R7 read with coincident set", 32'h1);
    rd(32'h8, 8'h00, 1'b0, 32'h0, "R7 new set kept", 32'h2);
    pulse_set(8'h01);
    rd(32'h8, 8'h01, 1'b0, 32'h0, "R7 same bit set and cleared", 32'h1);
    rd(32'h8, 8'h00, 1'b0, 32'h0, "R7 same bit survives", 32'h1);
    rd(32'h8, 8'h00, 1'b0, 32'h0, "R7 cleared after", 32'h0);
    quiet();

    // R8 remaining entry, empty read, overflow drop
    rd(32'hC, 8'h0, 1'b0, 32'h0, "R8 last entry", 32'hA3);
    rd(32'hC, 8'h0, 1'b0, 32'h0, "R8 empty read zero", 32'h0);
    quiet();
    for (int k = 0; k < 5; k++) pulse_push(32'hB0 + k);
    for (int k = 0; k < 4; k++) rd(32'hC, 8'h0, 1'b0, 32'h0, "R8 drain after full", 32'hB0 + k);
    rd(32'hC, 8'h0, 1'b0, 32'h0, "R8 overflow dropped", 32'h0);
    quiet();

    // R8 push and pop in one cycle
    pulse_push(32'hC0);
    rd(32'hC, 8'h0, 1'b1, 32'hC1, "R8 pop with push", 32'hC0);
    rd(32'hC, 8'h0, 1'b0, 32'h0, "R8 pushed word", 32'hC1);
    rd(32'hC, 8'h0, 1'b0, 32'h0, "R8 empty again", 32'h0);
    quiet();

    // R6 on idle and busy cycles
    @(negedge clk); hsel = 1'b1; htrans = 2'b01; haddr = 32'h8;
    #1 check_eq("R6 busy cycle", {30'd0, hreadyout, hresp}, 32'h2);
    quiet();

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule